// File: doc/BRIEF.md
# Fixed-Latency Line-Fill Memory Responder

This block sits on the memory side of a cache's line-fill bus. It holds a small word-addressed RAM. The requester offers read and write requests, and each request carries a byte address and a byte size. A write stores its words into the RAM on the accepting clock edge and produces nothing more. A read copies the words it names out of the RAM on the accepting edge and parks them in a pending queue. Each queued read then waits its own fixed latency before it may be answered.

When the cache raises its fill-accept input, the responder presents the oldest expired read. The response carries that read's base address and line data, and the read leaves the queue on that edge. A stall output refuses new requests in two cases: once in every stall period of cycles, and whenever the queue is full.

Top module: `fill_responder`

## Requirements
- R1: During reset and in the first cycle after it, the queue is empty, rsp_valid is 0, rsp_addr is 0, rsp_data is 0, and stall is 1 because the cycle count is 0.
- R2: stall is 1 exactly when the number of clock edges since reset, taken modulo STALL_PERIOD (16), is 0, or when the queue holds DEPTH (4) reads.
- R3: A request offered while stall is 1 has no effect. It writes no RAM word and queues no read.
- R4: A read accepted on clock edge E can first be answered in the cycle that follows edge E+LATENCY (LATENCY = 8).
- R5: rsp_valid is 1 only while fill_accept is 1 and at least one queued read has expired. In every other cycle, rsp_valid, rsp_addr and rsp_data are all 0.
- R6: When several queued reads have expired, the one accepted earliest is answered first. The answered read leaves the queue on the edge that ends the response cycle.
- R7: A response gives the request's byte address on rsp_addr. Bits [32*i+31:32*i] of rsp_data hold RAM word (req_addr/4 + i), for i < req_size/4. The higher words are 0. A size above LINE_BYTES is treated as a full line.
- R8: An accepted write stores word i of req_wdata (bits [32*i+31:32*i]) into RAM word (req_addr/4 + i), for i < req_size/4, on the accepting edge. It queues nothing and never causes a response.
- R9: Read data is captured on the accepting edge. A later write to the same words does not change a response that is already queued.
- R10: A request that has both req_read and req_write set queues the RAM contents from before its own write, and also performs the write.
- R11: RAM word addresses wrap modulo RAM_WORDS (64), both for reads and for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered this cycle |
| req_read | input | 1 | The request reads a line into the queue |
| req_write | input | 1 | The request writes words into the RAM |
| req_addr | input | ADDR_W (32) | Byte base address |
| req_size | input | SIZE_W (5) | Request size in bytes |
| req_wdata | input | LINE_WORDS*32 (128) | Write words, word 0 in the low bits |
| stall | output | 1 | Requests are refused this cycle |
| fill_accept | input | 1 | The cache can take a fill this cycle |
| rsp_valid | output | 1 | A fill response is presented |
| rsp_addr | output | ADDR_W (32) | Base address of the presented fill |
| rsp_data | output | LINE_WORDS*32 (128) | Data of the presented fill |

## Verification
The hardest state to reach from the ports is a full queue whose reads have all expired while fill_accept stays low. In that state the occupancy term of the stall output is the only thing guarding the RAM. To get there, the bench issues reads with fill_accept held low until the occupancy stall appears. It then offers a write during the stall and drains the queue. A later readback shows that the refused write left the RAM unchanged. A reference model in the bench tracks the edge count and the queue order in every cycle, so the exact latency cycle and the periodic stall slots are checked throughout.

// File: rtl/fr_pkg.sv
package fr_pkg;
   localparam int WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fr_backing_ram.sv
module fr_backing_ram #(
   parameter int WORDS      = 64,
   parameter int LINE_WORDS = 4,
   parameter int AW         = 6,
   parameter int NW_W       = 5
) (
   input  logic                         clk,
   input  logic                         wr_en,
   input  logic [AW-1:0]                wr_base,
   input  logic [NW_W-1:0]              wr_nwords,
   input  logic [LINE_WORDS*32-1:0]     wr_line,
   input  logic [AW-1:0]                rd_base,
   output logic [LINE_WORDS*32-1:0]     rd_line
);
   import fr_pkg::*;

   word_t mem [WORDS];

   // R11: word addresses wrap because the sum keeps AW bits
   always_ff @(posedge clk) begin
      for (int i = 0; i < LINE_WORDS; i++) begin
         if (wr_en && (NW_W'(i) < wr_nwords))
            mem[wr_base + AW'(i)] <= wr_line[i*32 +: 32];
      end
   end

   for (genvar g = 0; g < LINE_WORDS; g++) begin : g_rd
      assign rd_line[g*32 +: 32] = mem[rd_base + AW'(g)];
   end
endmodule

// File: rtl/fr_stall_gen.sv
module fr_stall_gen #(
   parameter int PERIOD = 16,
   parameter int DEPTH  = 4,
   parameter int OCC_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] occupancy,
   output logic             stall
);
   localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

   if (PERIOD < 2) begin : g_bad_period
      $error("fr_stall_gen: PERIOD must be at least 2");
   end

   logic [CW-1:0] cyc_q;

   if ((PERIOD & (PERIOD - 1)) == 0) begin : g_pow2
      always_ff @(posedge clk) begin
         if (!rst_n) cyc_q <= '0;
         else        cyc_q <= cyc_q + 1'b1;
      end
   end else begin : g_mod
      always_ff @(posedge clk) begin
         if (!rst_n)                       cyc_q <= '0;
         else if (cyc_q == CW'(PERIOD-1))  cyc_q <= '0;
         else                              cyc_q <= cyc_q + 1'b1;
      end
   end

   assign stall = (cyc_q == '0) || (occupancy >= OCC_W'(DEPTH));

   assert_period_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == CW'(PERIOD-1)) |=> stall);
endmodule

// File: rtl/fr_pending_queue.sv
module fr_pending_queue #(
   parameter int DEPTH      = 4,
   parameter int LATENCY    = 8,
   parameter int ADDR_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int OCC_W      = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [ADDR_W-1:0]        push_addr,
   input  logic [LINE_WORDS*32-1:0] push_line,
   input  logic                     take,
   output logic                     hit,
   output logic [ADDR_W-1:0]        hit_addr,
   output logic [LINE_WORDS*32-1:0] hit_line,
   output logic [OCC_W-1:0]         occupancy
);
   localparam int CNT_W  = $clog2(LATENCY + 1);
   localparam int LINE_W = LINE_WORDS * 32;

   logic [DEPTH-1:0]   v_q,    v_d;
   logic [CNT_W-1:0]   cnt_q   [DEPTH];
   logic [CNT_W-1:0]   cnt_d   [DEPTH];
   logic [ADDR_W-1:0]  addr_q  [DEPTH];
   logic [ADDR_W-1:0]  addr_d  [DEPTH];
   logic [LINE_W-1:0]  line_q  [DEPTH];
   logic [LINE_W-1:0]  line_d  [DEPTH];
   int                 sel;
   logic               pop;

   // Slot 0 is the oldest entry; valid slots stay packed at the low end.
   always_comb begin
      hit = 1'b0;
      sel = 0;
      for (int i = DEPTH-1; i >= 0; i--) begin
         if (v_q[i] && (cnt_q[i] == '0)) begin
            hit = 1'b1;
            sel = i;
         end
      end
   end

   assign occupancy = OCC_W'($countones(v_q));
   assign pop       = hit && take;
   assign hit_addr  = addr_q[sel];
   assign hit_line  = line_q[sel];

   always_comb begin
      int src;
      int pos;
      for (int i = 0; i < DEPTH; i++) begin
         src = (pop && (i >= sel)) ? i + 1 : i;
         if (src < DEPTH) begin
            v_d[i]    = v_q[src];
            cnt_d[i]  = (cnt_q[src] == '0) ? '0 : cnt_q[src] - 1'b1;
            addr_d[i] = addr_q[src];
            line_d[i] = line_q[src];
         end else begin
            v_d[i]    = 1'b0;
            cnt_d[i]  = '0;
            addr_d[i] = '0;
            line_d[i] = '0;
         end
      end
      pos = int'(occupancy) - (pop ? 1 : 0);
      for (int i = 0; i < DEPTH; i++) begin
         if (push && (i == pos)) begin
            v_d[i]    = 1'b1;
            cnt_d[i]  = CNT_W'(LATENCY);
            addr_d[i] = push_addr;
            line_d[i] = push_line;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            cnt_q[i]  <= '0;
            addr_q[i] <= '0;
            line_q[i] <= '0;
         end
      end else begin
         v_q <= v_d;
         for (int i = 0; i < DEPTH; i++) begin
            cnt_q[i]  <= cnt_d[i];
            addr_q[i] <= addr_d[i];
            line_q[i] <= line_d[i];
         end
      end
   end

   assert_no_push_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (occupancy < OCC_W'(DEPTH)));

   assert_pop_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> (occupancy == $past(occupancy) - 1'b1));
endmodule

// File: rtl/fill_responder.sv
module fill_responder #(
   parameter int ADDR_W       = 32,
   parameter int RAM_WORDS    = 64,
   parameter int LINE_BYTES   = 16,
   parameter int DEPTH        = 4,
   parameter int LATENCY      = 8,
   parameter int STALL_PERIOD = 16,
   localparam int LINE_WORDS  = LINE_BYTES / 4,
   localparam int SIZE_W      = $clog2(LINE_BYTES + 1),
   localparam int LINE_W      = LINE_WORDS * 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_read,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [SIZE_W-1:0]  req_size,
   input  logic [LINE_W-1:0]  req_wdata,
   output logic               stall,
   input  logic               fill_accept,
   output logic               rsp_valid,
   output logic [ADDR_W-1:0]  rsp_addr,
   output logic [LINE_W-1:0]  rsp_data
);
   localparam int RAM_AW = $clog2(RAM_WORDS);
   localparam int OCC_W  = $clog2(DEPTH + 1);

   if ((LINE_BYTES % 4) != 0 || LINE_BYTES < 4) begin : g_bad_line
      $error("fill_responder: LINE_BYTES must be a positive multiple of 4");
   end
   if ((RAM_WORDS & (RAM_WORDS - 1)) != 0 || RAM_WORDS < LINE_WORDS) begin : g_bad_ram
      $error("fill_responder: RAM_WORDS must be a power of two and hold a line");
   end
   if (LATENCY < 1 || DEPTH < 1) begin : g_bad_queue
      $error("fill_responder: LATENCY and DEPTH must be at least 1");
   end

   logic               take;
   logic [SIZE_W-1:0]  nwords;
   logic [RAM_AW-1:0]  base_w;
   logic [LINE_W-1:0]  ram_line;
   logic [LINE_W-1:0]  cap_line;
   logic               q_hit;
   logic [ADDR_W-1:0]  q_addr;
   logic [LINE_W-1:0]  q_line;
   logic [OCC_W-1:0]   q_occ;

   assign take   = req_valid && !stall;
   assign nwords = ((req_size >> 2) > SIZE_W'(LINE_WORDS)) ? SIZE_W'(LINE_WORDS) : (req_size >> 2);
   assign base_w = req_addr[2 +: RAM_AW];

   fr_backing_ram #(
      .WORDS(RAM_WORDS), .LINE_WORDS(LINE_WORDS), .AW(RAM_AW), .NW_W(SIZE_W)
   ) u_ram (
      .clk(clk),
      .wr_en(take && req_write),
      .wr_base(base_w),
      .wr_nwords(nwords),
      .wr_line(req_wdata),
      .rd_base(base_w),
      .rd_line(ram_line)
   );

   // R7: words past the requested size are returned as zero
   for (genvar g = 0; g < LINE_WORDS; g++) begin : g_mask
      assign cap_line[g*32 +: 32] = (SIZE_W'(g) < nwords) ? ram_line[g*32 +: 32] : 32'h0;
   end

   fr_pending_queue #(
      .DEPTH(DEPTH), .LATENCY(LATENCY), .ADDR_W(ADDR_W),
      .LINE_WORDS(LINE_WORDS), .OCC_W(OCC_W)
   ) u_queue (
      .clk(clk),
      .rst_n(rst_n),
      .push(take && req_read),
      .push_addr(req_addr),
      .push_line(cap_line),
      .take(fill_accept),
      .hit(q_hit),
      .hit_addr(q_addr),
      .hit_line(q_line),
      .occupancy(q_occ)
   );

   fr_stall_gen #(
      .PERIOD(STALL_PERIOD), .DEPTH(DEPTH), .OCC_W(OCC_W)
   ) u_stall (
      .clk(clk),
      .rst_n(rst_n),
      .occupancy(q_occ),
      .stall(stall)
   );

   assign rsp_valid = q_hit && fill_accept;
   assign rsp_addr  = rsp_valid ? q_addr : '0;
   assign rsp_data  = rsp_valid ? q_line : '0;

   assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> ((rsp_addr == '0) && (rsp_data == '0)));

   assert_rsp_needs_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> fill_accept);

   assert_write_no_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && req_write && !req_read) |=> (q_occ <= $past(q_occ)));
endmodule

// File: tb/fill_responder_bench.sv
module fill_responder_bench;
   localparam int AW = 32, RW = 64, LB = 16, DEP = 4, LAT = 8, PER = 16;
   localparam int LWD = LB / 4, SW = $clog2(LB + 1), LW = LWD * 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_read = 0, req_write = 0, fill_accept = 0;
   logic [AW-1:0] req_addr = '0;
   logic [SW-1:0] req_size = '0;
   logic [LW-1:0] req_wdata = '0;
   logic stall, rsp_valid;
   logic [AW-1:0] rsp_addr;
   logic [LW-1:0] rsp_data;

   fill_responder u_fill_responder (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
      .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .stall(stall), .fill_accept(fill_accept),
      .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
   );

   always #10 clk = ~clk;

   int checks = 0, fails = 0;
   logic [31:0] m_ram [RW];
   int          q_n = 0;
   logic [AW-1:0] q_addr [DEP];
   logic [LW-1:0] q_line [DEP];
   int          q_cnt  [DEP];
   int          edges = 0;

   task automatic chk(string tag, logic [LW-1:0] act, logic [LW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(string tag, bit v, bit rd, bit wr, logic [AW-1:0] a,
                       int sz, logic [LW-1:0] wd, bit acc, output bit taken);
      bit e_st, e_rv;
      int sel, nw, wb;
      logic [LW-1:0] line;
      req_valid = v; req_read = rd; req_write = wr; req_addr = a;
      req_size = SW'(sz); req_wdata = wd; fill_accept = acc;
      @(negedge clk);
      e_st = ((edges % PER) == 0) || (q_n == DEP);
      sel = -1;
      for (int i = q_n - 1; i >= 0; i--) if (q_cnt[i] == 0) sel = i;
      e_rv = acc && (sel >= 0);
      chk({tag, " stall"}, LW'(stall), LW'(e_st));
      chk({tag, " rsp_valid"}, LW'(rsp_valid), LW'(e_rv));
      chk({tag, " rsp_addr"}, LW'(rsp_addr), e_rv ? LW'(q_addr[sel]) : '0);
      chk({tag, " rsp_data"}, rsp_data, e_rv ? q_line[sel] : '0);
      taken = v && !e_st;
      nw = (sz / 4 > LWD) ? LWD : sz / 4;
      wb = int'(a >> 2) % RW;
      line = '0;
      if (taken && rd)
         for (int i = 0; i < nw; i++) line[i*32 +: 32] = m_ram[(wb + i) % RW];
      if (e_rv) begin
         for (int i = sel; i < q_n - 1; i++) begin
            q_addr[i] = q_addr[i+1]; q_line[i] = q_line[i+1]; q_cnt[i] = q_cnt[i+1];
         end
         q_n--;
      end
      for (int i = 0; i < q_n; i++) if (q_cnt[i] > 0) q_cnt[i]--;
      if (taken && wr)
         for (int i = 0; i < nw; i++) m_ram[(wb + i) % RW] = wd[i*32 +: 32];
      if (taken && rd) begin
         q_addr[q_n] = a; q_line[q_n] = line; q_cnt[q_n] = LAT; q_n++;
      end
      edges++;
      @(posedge clk); #1;
   endtask

   task automatic issue(string tag, bit rd, bit wr, logic [AW-1:0] a, int sz,
                        logic [LW-1:0] wd, bit acc);
      bit tk;
      for (int k = 0; k < 40; k++) begin
         step(tag, 1, rd, wr, a, sz, wd, acc, tk);
         if (tk) break;
      end
   endtask

   task automatic idle(string tag, int n, bit acc);
      bit tk;
      for (int k = 0; k < n; k++) step(tag, 0, 0, 0, '0, 0, '0, acc, tk);
   endtask

   task automatic drain(string tag);
      bit tk;
      for (int k = 0; k < 200 && q_n > 0; k++) step(tag, 0, 0, 0, '0, 0, '0, 1, tk);
      step(tag, 0, 0, 0, '0, 0, '0, 1, tk);
   endtask

   function automatic logic [LW-1:0] pat(int seed);
      logic [LW-1:0] r;
      for (int i = 0; i < LWD; i++) r[i*32 +: 32] = 32'(seed * 32'h9E3779B1 + i * 32'h01010101 + 5);
      return r;
   endfunction

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      bit tk;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 rsp_valid in reset", LW'(rsp_valid), '0);
      chk("R1 stall in reset", LW'(stall), LW'(1));
      rst_n = 1'b1;
      edges = 0;
      idle("R1", 2, 1);

      // R8: fill the RAM through line writes
      for (int b = 0; b < RW; b += LWD) issue("R8", 0, 1, AW'(b * 4), LB, pat(b), 1);
      idle("R8 no entry", 12, 1);

      // R7: size sweep over several bases
      for (int sz = 0; sz <= LB + 4; sz += 4)
         for (int b = 0; b < 4; b++) begin
            issue("R7", 1, 0, AW'(b * 52 + 4), sz, '0, 1);
            drain("R7");
         end

      // R4: exact latency with accept held high
      issue("R4", 1, 0, AW'(32'h40), LB, '0, 1);
      idle("R4", LAT + 2, 1);

      // R5 / R6: expired reads held back, then released oldest first
      issue("R5", 1, 0, AW'(32'h10), LB, '0, 0);
      issue("R5", 1, 0, AW'(32'h80), 8, '0, 0);
      issue("R5", 1, 0, AW'(32'h30), 12, '0, 0);
      idle("R5", LAT + 4, 0);
      drain("R6");

      // R2 / R3: full queue stalls; a write offered then is dropped
      for (int k = 0; k < DEP; k++) issue("R2", 1, 0, AW'(k * 16), LB, '0, 0);
      idle("R2", LAT + 2, 0);
      step("R3", 1, 0, 1, AW'(0), LB, pat(999), 0, tk);
      chk("R3 write refused", LW'(tk), '0);
      drain("R3");
      issue("R3", 1, 0, AW'(0), LB, '0, 1);
      drain("R3");

      // R9: capture at acceptance
      issue("R9", 1, 0, AW'(32'h20), LB, '0, 1);
      issue("R9", 0, 1, AW'(32'h20), LB, pat(77), 1);
      drain("R9");

      // R10: read and write together
      issue("R10", 1, 1, AW'(32'h60), LB, pat(55), 1);
      drain("R10");
      issue("R10", 1, 0, AW'(32'h60), LB, '0, 1);
      drain("R10");

      // R11: wrap at the top of the RAM
      issue("R11", 0, 1, AW'((RW - 2) * 4), LB, pat(31), 1);
      issue("R11", 1, 0, AW'((RW - 2) * 4), LB, '0, 1);
      drain("R11");

      idle("R2 period", 2 * PER, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule